// File: doc/BRIEF.md
# Serial Presence-Detect Configuration Store

This block is a 256-byte configuration memory. A host reaches it over a two-wire serial bus in the I2C style. The block answers at one fixed 7-bit device address and takes a one-byte word address. It supports three transfers: byte (and back-to-back) writes, random reads done through a repeated START, and sequential reads. Bus lines are seen through a synchronizer running on a local clock. SDA is only ever pulled low through an open-drain enable, never driven high. A separate preload port fills the array with its initial contents before the bus is used.

Write permission depends on the byte address. The low half of the array never changes through the bus. The high half takes bus writes while the protect input is low; a board-level pull-down is expected to hold that input low when nothing drives it. A write that lands on a protected byte is still acknowledged, but the stored value is left as it was.

The transfer sequencer has ten states:

- IDLE waits for a START.
- DEV shifts in the device byte.
- DEV_ACK acknowledges a matching device address.
- WADR and WADR_ACK take in and acknowledge the word address.
- WDAT and WDAT_ACK take in and acknowledge each data byte.
- RD shifts a byte out.
- RD_ACK samples the master's acknowledge.
- PARK keeps SDA released until the next START or STOP.

Transitions happen on a detected SCL fall, with two exceptions. A START sends any state to DEV, and a STOP sends any state to IDLE. The transitions that depend on data are these:

- DEV goes to DEV_ACK on an address match, otherwise to PARK.
- DEV_ACK goes to RD for a read and to WADR for a write.
- RD_ACK goes to RD on an ACK and to PARK on a NACK.

Top module: `spd_eeprom`

## Requirements
- R1: While reset is held and directly after it, `sda_oe` is 0 and the block waits for a START.
- R2: A START (SDA falling while SCL is high) begins a new transfer from any state, including in the middle of a byte. A STOP (SDA rising while SCL is high) returns the block to idle.
- R3: The first byte after START carries the 7-bit device address, MSB first, followed by the direction bit (1 = read). The block pulls SDA low during the ninth clock only when the address equals `DEV_ADDR` (default 0x50). On any other address it leaves SDA released for the rest of the transfer.
- R4: In a write transfer, the second byte is the word address and is loaded into the address pointer. Each later byte is stored at the pointer, after which the pointer advances by one modulo 256. Every one of these bytes is acknowledged.
- R5: Bytes 0 to 127 never change through a bus write, and such a write is still acknowledged.
- R6: Bytes 128 to 255 take the written value while `wp_i` is 0.
- R7: While `wp_i` is 1, bus writes to bytes 128 to 255 leave them unchanged and are still acknowledged.
- R8: A read transfer returns the byte at the pointer, MSB first, with SDA pulled low for each 0 bit. The pointer advances after every byte and wraps from 255 to 0.
- R9: An ACK from the master (SDA low on the ninth clock) makes the block send the next byte. A NACK ends the read, and SDA stays released until the next START or STOP.
- R10: While `pre_en` is 1, `pre_data` is written to `pre_addr` on the clock edge, regardless of write protection.
- R11: `sda_oe` changes only after a detected SCL fall, so it never changes while SCL is high during data transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin (wired-AND level) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| wp_i | input | 1 | Write protect for the upper half, active high |
| pre_en | input | 1 | Preload strobe |
| pre_addr | input | 8 | Preload byte address |
| pre_data | input | 8 | Preload byte value |

## Verification
The bench builds the block with its default parameters: device address 0x50, a lock boundary of 128, 8-bit addresses and data, and a two-stage synchronizer. With these values the bench can reach the corners that matter. It writes across the 255-to-0 wrap so that one byte of the burst lands in the locked low half, and it reads sequentially through the same wrap. It sends a foreign device address (0x52) and restarts in the middle of a byte. Each SCL phase lasts eight clocks, which is longer than the synchronizer delay, so on every clock the bench can compare `sda_oe` against the windows in which its behavioural model allows the slave to drive.

// File: rtl/spd_pkg.sv
package spd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_PARK
    } spd_state_e;

endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_now;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        scl_chain[0] <= 1'b1;
                        sda_chain[0] <= 1'b1;
                    end else begin
                        scl_chain[0] <= scl_i;
                        sda_chain[0] <= sda_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        scl_chain[g] <= 1'b1;
                        sda_chain[g] <= 1'b1;
                    end else begin
                        scl_chain[g] <= scl_chain[g-1];
                        sda_chain[g] <= sda_chain[g-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_chain[SYNC_STAGES-1];
            sda_prev <= sda_chain[SYNC_STAGES-1];
        end
    end

    always_comb begin
        scl_now   = scl_chain[SYNC_STAGES-1];
        sda_q     = sda_chain[SYNC_STAGES-1];
        scl_rise  = scl_now & ~scl_prev;
        scl_fall  = ~scl_now & scl_prev;
        start_det = scl_now & scl_prev & sda_prev & ~sda_q;
        stop_det  = scl_now & scl_prev & ~sda_prev & sda_q;
    end

endmodule

// File: rtl/spd_store.sv
module spd_store #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int LOCK_BOUND = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_en,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [DATA_W-1:0] pre_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wp,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int                DEPTH    = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LOCK_LIM = ADDR_W'(LOCK_BOUND);

    logic [DATA_W-1:0] mem [DEPTH];
    logic              wr_ok;

    always_comb begin
        wr_ok   = (wr_addr >= LOCK_LIM) && !wp;
        rd_data = mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (pre_en) begin
            mem[pre_addr] <= pre_data;
        end else if (wr_en && wr_ok) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // R5: locked lower region keeps its byte through a bus write
    p_lock_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pre_en && (wr_addr < LOCK_LIM)) |=>
            (mem[$past(wr_addr)] == $past(mem[wr_addr])));

    // R7: protect pin holds the byte unchanged
    p_wp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pre_en && wp) |=>
            (mem[$past(wr_addr)] == $past(mem[wr_addr])));

    // R6: unprotected upper byte takes the written value
    p_upper_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pre_en && !wp && (wr_addr >= LOCK_LIM)) |=>
            (mem[$past(wr_addr)] == $past(wr_data)));

    // R10: preload lands regardless of protection
    p_preload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |=> (mem[$past(pre_addr)] == $past(pre_data)));

endmodule

// File: rtl/spd_fsm.sv
module spd_fsm
    import spd_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter logic [6:0]  DEV_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_q,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] ptr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int                CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(DATA_W);

    spd_state_e        state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] tx;
    logic              mack;
    logic              byte_done;
    logic              bus_evt;

    assign byte_done = (cnt == CNT_FULL);
    assign bus_evt   = start_det | stop_det;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decision
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_DEV;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_DEV:      if (byte_done)
                                 nxt = (shreg[DATA_W-1:DATA_W-7] == DEV_ADDR) ? ST_DEV_ACK : ST_PARK;
                ST_DEV_ACK:  nxt = shreg[0] ? ST_RD : ST_WADR;
                ST_WADR:     if (byte_done) nxt = ST_WADR_ACK;
                ST_WADR_ACK: nxt = ST_WDAT;
                ST_WDAT:     if (byte_done) nxt = ST_WDAT_ACK;
                ST_WDAT_ACK: nxt = ST_WDAT;
                ST_RD:       if (byte_done) nxt = ST_RD_ACK;
                ST_RD_ACK:   nxt = mack ? ST_PARK : ST_RD;
                ST_PARK:     nxt = ST_PARK;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe  = 1'b0;
        wr_en   = 1'b0;
        wr_data = shreg;
        unique case (state)
            ST_DEV_ACK, ST_WADR_ACK, ST_WDAT_ACK: sda_oe = 1'b1;
            ST_RD:   sda_oe = ~tx[DATA_W-1];
            ST_WDAT: wr_en  = scl_fall & byte_done & ~bus_evt;
            default: sda_oe = 1'b0;
        endcase
    end

    // datapath: shift register, bit count, pointer, transmit byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            tx    <= '0;
            ptr   <= '0;
            mack  <= 1'b1;
        end else if (bus_evt) begin
            cnt <= '0;
        end else if (scl_rise) begin
            unique case (state)
                ST_DEV, ST_WADR, ST_WDAT: begin
                    shreg <= {shreg[DATA_W-2:0], sda_q};
                    cnt   <= cnt + 1'b1;
                end
                ST_RD:     cnt  <= cnt + 1'b1;
                ST_RD_ACK: mack <= sda_q;
                default:   cnt  <= cnt;
            endcase
        end else if (scl_fall) begin
            unique case (state)
                ST_DEV: if (byte_done) cnt <= '0;
                ST_WADR: if (byte_done) begin
                    cnt <= '0;
                    ptr <= shreg[ADDR_W-1:0];
                end
                ST_WDAT: if (byte_done) begin
                    cnt <= '0;
                    ptr <= ptr + 1'b1;
                end
                ST_DEV_ACK: begin
                    cnt <= '0;
                    if (shreg[0]) begin
                        tx  <= rd_data;
                        ptr <= ptr + 1'b1;
                    end
                end
                ST_RD: begin
                    if (byte_done) cnt <= '0;
                    else           tx  <= {tx[DATA_W-2:0], 1'b0};
                end
                ST_RD_ACK: begin
                    cnt <= '0;
                    if (!mack) begin
                        tx  <= rd_data;
                        ptr <= ptr + 1'b1;
                    end
                end
                default: cnt <= cnt;
            endcase
        end
    end

    // R2: a START always leads to device-byte reception
    p_start_dev_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV));

    // R2: a STOP returns to idle
    p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE));

    // R11: the open-drain enable moves only after an SCL fall or bus condition
    p_oe_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    // R4: each stored byte advances the pointer by one
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == $past(ptr) + 1'b1));

    // R9: a NACK parks the slave with SDA released
    p_nack_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK && scl_fall && mack && !bus_evt) |=> (state == ST_PARK && !sda_oe));

endmodule

// File: rtl/spd_eeprom.sv
module spd_eeprom #(
    parameter int         ADDR_W      = 8,
    parameter int         DATA_W      = 8,
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         LOCK_BOUND  = 128,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              wp_i,
    input  logic              pre_en,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [DATA_W-1:0] pre_data
);

    logic              sda_q;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              wr_en;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    spd_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_q    (sda_q),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    spd_fsm #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .DEV_ADDR(DEV_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_q    (sda_q),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .wr_en    (wr_en),
        .ptr      (ptr),
        .wr_data  (wr_data)
    );

    spd_store #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .LOCK_BOUND(LOCK_BOUND)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .pre_en  (pre_en),
        .pre_addr(pre_addr),
        .pre_data(pre_data),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (wr_data),
        .wp      (wp_i),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/spd_eeprom_tb.sv
`timescale 1ns/1ps
module spd_eeprom_tb;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       md = 1'b1;
    logic       wp = 1'b0;
    logic       pre_en = 1'b0;
    logic [7:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    logic       sda_oe;
    logic       sda_line;

    int  tests = 0;
    int  fails = 0;
    bit  may_drive = 1'b0;
    bit  mon_on = 1'b0;
    bit  done = 1'b0;

    byte unsigned exp_mem [256];
    int  mptr = 0;

    always #4 clk = ~clk;

    assign sda_line = md & ~sda_oe;

    spd_eeprom u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .wp_i    (wp),
        .pre_en  (pre_en),
        .pre_addr(pre_addr),
        .pre_data(pre_data)
    );

    // per-clock model: slave may pull SDA only inside its own windows (R11, R9, R3)
    always @(negedge clk) begin
        if (mon_on) begin
            tests++;
            if (sda_oe && !may_drive) begin
                fails++;
                $display("FAIL R11/R9: sda_oe actual %0d expected 0 outside slave window at %0t", sda_oe, $time);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        md = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        md = 1'b0; tick(Q);
        scl = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        md = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        md = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input bit b);
        md = b; tick(Q);
        scl = 1'b1; tick(Q);
        scl = 1'b0; tick(1);
    endtask

    task automatic recv_bit(output bit b);
        may_drive = 1'b1;
        md = 1'b1; tick(Q);
        scl = 1'b1; tick(Q / 2);
        b = sda_line; tick(Q / 2);
        scl = 1'b0; tick(4);
        may_drive = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(ack);
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit nack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(nack);
    endtask

    // write burst; model applies lock and protect rules
    task automatic do_write(input logic [7:0] addr, input byte unsigned d[$], input string req);
        bit ack;
        bus_start();
        send_byte({7'h50, 1'b0}, ack); chk("R3 device ack (write)", ack, 0);
        send_byte(addr, ack);          chk("R4 word address ack", ack, 0);
        mptr = addr;
        foreach (d[i]) begin
            send_byte(d[i], ack);
            chk({req, " data ack"}, ack, 0);
            if (mptr >= 128 && !wp) exp_mem[mptr] = d[i];
            mptr = (mptr + 1) % 256;
        end
        bus_stop();
    endtask

    // random read of n bytes via repeated START
    task automatic do_read(input logic [7:0] addr, input int n, input string req);
        bit ack;
        logic [7:0] v;
        bus_start();
        send_byte({7'h50, 1'b0}, ack); chk("R3 device ack (dummy write)", ack, 0);
        send_byte(addr, ack);          chk("R4 word address ack", ack, 0);
        mptr = addr;
        bus_start();
        send_byte({7'h50, 1'b1}, ack); chk("R3 device ack (read)", ack, 0);
        for (int i = 0; i < n; i++) begin
            recv_byte(v, (i == n - 1));
            chk(req, v, exp_mem[mptr]);
            mptr = (mptr + 1) % 256;
        end
        bus_stop();
    endtask

    initial begin
        bit ack;
        logic [7:0] v;

        // R1: reset state
        tick(3);
        chk("R1 sda_oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        tick(2);
        chk("R1 sda_oe after reset", sda_oe, 0);

        // R10: preload the whole array
        for (int i = 0; i < 256; i++) begin
            pre_en = 1'b1;
            pre_addr = 8'(i);
            pre_data = 8'((i * 37 + 11) & 8'hff);
            exp_mem[i] = byte'((i * 37 + 11) & 8'hff);
            tick(1);
        end
        pre_en = 1'b0;
        tick(4);
        mon_on = 1'b1;

        // R10 / R8: preloaded bytes read back
        do_read(8'd5, 1, "R10 preload readback low");
        do_read(8'd190, 2, "R10 preload readback high");

        // R5: locked lower byte
        do_write(8'd10, '{8'hA5}, "R5 locked write");
        do_read(8'd10, 1, "R5 lower byte unchanged");

        // R6: upper byte writable with wp low
        do_write(8'd200, '{8'h3C}, "R6 upper write");
        do_read(8'd200, 1, "R6 upper byte updated");

        // R7: wp high blocks upper writes
        wp = 1'b1;
        tick(2);
        do_write(8'd201, '{8'h77}, "R7 protected write");
        wp = 1'b0;
        do_read(8'd201, 1, "R7 upper byte unchanged");

        // R4/R5/R6: burst crossing 255 -> 0
        do_write(8'd254, '{8'h11, 8'h22, 8'h33}, "R4 burst");
        // R8/R9: sequential read through the wrap
        do_read(8'd253, 5, "R8 sequential read with wrap");

        // R3: foreign device address gets no ack
        bus_start();
        send_byte({7'h52, 1'b1}, ack);
        chk("R3 foreign address NACK", ack, 1);
        bus_stop();

        // R8: current-address read continues at the pointer
        bus_start();
        send_byte({7'h50, 1'b1}, ack); chk("R3 device ack (current read)", ack, 0);
        recv_byte(v, 1'b1);
        chk("R8 current-address read", v, exp_mem[mptr]);
        mptr = (mptr + 1) % 256;
        bus_stop();

        // R2: START in the middle of a byte restarts the transfer
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        send_byte({7'h50, 1'b1}, ack); chk("R2 ack after mid-byte restart", ack, 0);
        recv_byte(v, 1'b1);
        chk("R2 read after restart", v, exp_mem[mptr]);
        mptr = (mptr + 1) % 256;
        bus_stop();

        // R9: after NACK+STOP, bus idle and SDA released
        tick(20);
        chk("R9 released after NACK", sda_oe, 0);

        mon_on = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule